// File: doc/BRIEF.md
# Transmit Endpoint Control Logic

This block holds the control and status state of one transmit endpoint in a USB controller. A CPU reads and writes an 8-bit control byte over a single-cycle register port. The byte enables automatic packet-ready detection, DMA requests and the DMA interrupt mode. It also forces a data-toggle flip with a FIFO flush and selects the direction of a FIFO shared between transmit and receive.

A packet loader pulses one strobe per byte written into the endpoint FIFO. The block counts these strobes against a programmable maximum packet size. When auto-set is on, it raises transmit-ready by itself once a full-size packet has been loaded. A shorter packet needs a manual set by software. When an ACK arrives for the sent packet, the block clears transmit-ready and the byte count and flips the data toggle. A forced toggle does the same without any handshake and also requests a FIFO flush.

Top module: `tx_ep_ctrl`

## Requirements
- R1: After reset, reg_rdata_o is 0x00, and txrdy_o, flush_o, dma_req_o, dma_irq_o and mode_err_o are all 0.
- R2: Control byte layout: bit 7 auto-set, bit 6 reserved, bit 5 direction, bit 4 DMA enable, bit 3 force toggle, bit 2 DMA interrupt mode, bit 1 data toggle, bit 0 transmit-ready. Bit 6 always reads 0. Bit 1 ignores register writes.
- R3: With bit 7 = 1 and max_pkt_i != 0, the clock edge that accepts the max_pkt_i-th fifo_wr_i strobe since the last clear also sets transmit-ready.
- R4: Transmit-ready is not set automatically when fewer than max_pkt_i bytes are loaded, when bit 7 = 0, or when max_pkt_i = 0.
- R5: A register write with bit 0 = 1 sets transmit-ready. Writing 0 to bit 0 has no effect on it.
- R6: ack_i clears transmit-ready and the byte count, and flips the data toggle on the same edge.
- R7: A write with bit 3 = 1 makes flush_o high for exactly the next cycle, with bit 3 reading 1 during that cycle. The following edge flips the data toggle, clears transmit-ready and the byte count, and returns bit 3 to 0. This happens whether or not an ACK arrives.
- R8: When shared_fifo_i = 1, dir_tx_o equals bit 5. When shared_fifo_i = 0, dir_tx_o is 1.
- R9: dma_req_o is high exactly when bit 4 = 1 and transmit-ready = 0.
- R10: With bit 4 = 1, dma_irq_o pulses one cycle after dma_pkt_done_i when bit 2 = 0, and one cycle after dma_all_done_i when bit 2 = 1. The other done input is ignored. With bit 4 = 0, dma_irq_o stays 0.
- R11: A write with bit 2 = 0 while bits 2 and 4 both currently read 1 leaves bit 2 at 1 and pulses mode_err_o in the next cycle. The other fields of that write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control byte write strobe |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Control byte read data |
| fifo_wr_i | input | 1 | One byte loaded into the FIFO |
| max_pkt_i | input | 11 | Maximum packet size in bytes |
| ack_i | input | 1 | Sent packet acknowledged |
| shared_fifo_i | input | 1 | FIFO is shared by both directions |
| txrdy_o | output | 1 | Packet ready to transmit |
| flush_o | output | 1 | FIFO flush request |
| dir_tx_o | output | 1 | FIFO direction, 1 = transmit |
| dma_pkt_done_i | input | 1 | DMA finished one packet |
| dma_all_done_i | input | 1 | DMA finished whole transfer |
| dma_req_o | output | 1 | DMA request |
| dma_irq_o | output | 1 | DMA interrupt pulse |
| mode_err_o | output | 1 | DMA mode ordering violation |

## Verification
The auto-set path is swept over maximum sizes 1 to 6, loading every packet length from 0 up to the maximum, with auto-set both on and off. This separates an early or late trigger (an off-by-one in the count) from a trigger that ignores the enable. Each packet ends with an ACK, with a manual set first where needed, so a byte count that is not cleared would show as a wrong trigger in the next packet. Further runs with maximum size 0 and with forced toggles in the middle of a load catch a missing clear on the flush path. The DMA interrupt is driven with each done input under each mode, and the ordering rule is tested with both a violating and a legal clearing sequence.

// File: rtl/tx_ep_pkg.sv
package tx_ep_pkg;
  localparam int unsigned BIT_AUTO  = 7;
  localparam int unsigned BIT_RSVD  = 6;
  localparam int unsigned BIT_DIR   = 5;
  localparam int unsigned BIT_DMAEN = 4;
  localparam int unsigned BIT_FTOG  = 3;
  localparam int unsigned BIT_DMOD  = 2;
  localparam int unsigned BIT_TOG   = 1;
  localparam int unsigned BIT_RDY   = 0;

  typedef struct packed {
    logic auto_set;
    logic dir_tx;
    logic dma_en;
    logic force_tog;
    logic dma_mode;
  } ctrl_t;
endpackage

// File: rtl/tx_ep_regs.sv
module tx_ep_regs
  import tx_ep_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o,
  output logic          set_rdy_o,
  output logic          mode_err_o
);
  ctrl_t ctrl_q;
  logic  bad_clr;

  // clearing mode while DMA enabled (before or with enable clear)
  assign bad_clr = we_i && !wdata_i[BIT_DMOD] && ctrl_q.dma_mode && ctrl_q.dma_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      mode_err_o <= 1'b0;
    end else begin
      ctrl_q.force_tog <= we_i && wdata_i[BIT_FTOG];
      mode_err_o       <= bad_clr;
      if (we_i) begin
        ctrl_q.auto_set <= wdata_i[BIT_AUTO];
        ctrl_q.dir_tx   <= wdata_i[BIT_DIR];
        ctrl_q.dma_en   <= wdata_i[BIT_DMAEN];
        if (!bad_clr) ctrl_q.dma_mode <= wdata_i[BIT_DMOD];
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign set_rdy_o = we_i && wdata_i[BIT_RDY];

  // R11
  mode_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> ctrl_q.dma_mode);
endmodule

// File: rtl/tx_ep_pktcnt.sv
module tx_ep_pktcnt #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign full_o  = en_i && wr_i && !clr_i && (max_i != '0) &&
                   (cnt_inc == {1'b0, max_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (wr_i && cnt_q != CNT_MAX)   cnt_q <= cnt_inc[CNT_W-1:0];
  end

  // R6
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tx_ep_dma.sv
module tx_ep_dma (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic dma_mode_i,
  input  logic txrdy_i,
  input  logic pkt_done_i,
  input  logic all_done_i,
  output logic req_o,
  output logic irq_o
);
  logic irq_src;

  assign req_o   = dma_en_i && !txrdy_i;
  assign irq_src = dma_en_i && (dma_mode_i ? all_done_i : pkt_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_src;
  end

  // R10
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_en_i && !pkt_done_i && !all_done_i) |=> !irq_o);
endmodule

// File: rtl/tx_ep_ctrl.sv
module tx_ep_ctrl
  import tx_ep_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             fifo_wr_i,
  input  logic [CNT_W-1:0] max_pkt_i,
  input  logic             ack_i,
  input  logic             shared_fifo_i,
  output logic             txrdy_o,
  output logic             flush_o,
  output logic             dir_tx_o,
  input  logic             dma_pkt_done_i,
  input  logic             dma_all_done_i,
  output logic             dma_req_o,
  output logic             dma_irq_o,
  output logic             mode_err_o
);
  ctrl_t ctrl;
  logic  set_rdy, full_hit, pkt_clr;
  logic  txrdy_q, tog_q;
  logic  unused_wbits;

  assign unused_wbits = ^{reg_wdata_i[BIT_RSVD], reg_wdata_i[BIT_TOG]};

  tx_ep_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl), .set_rdy_o(set_rdy), .mode_err_o
  );

  assign flush_o = ctrl.force_tog;
  assign pkt_clr = ack_i || ctrl.force_tog;

  tx_ep_pktcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .wr_i(fifo_wr_i), .clr_i(pkt_clr),
    .en_i(ctrl.auto_set), .max_i(max_pkt_i), .full_o(full_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txrdy_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      if (pkt_clr)                  txrdy_q <= 1'b0;
      else if (set_rdy || full_hit) txrdy_q <= 1'b1;
      if (pkt_clr) tog_q <= ~tog_q;
    end
  end

  tx_ep_dma u_dma (
    .clk_i, .rst_ni, .dma_en_i(ctrl.dma_en), .dma_mode_i(ctrl.dma_mode),
    .txrdy_i(txrdy_q), .pkt_done_i(dma_pkt_done_i),
    .all_done_i(dma_all_done_i), .req_o(dma_req_o), .irq_o(dma_irq_o)
  );

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[BIT_AUTO]  = ctrl.auto_set;
    reg_rdata_o[BIT_DIR]   = ctrl.dir_tx;
    reg_rdata_o[BIT_DMAEN] = ctrl.dma_en;
    reg_rdata_o[BIT_FTOG]  = ctrl.force_tog;
    reg_rdata_o[BIT_DMOD]  = ctrl.dma_mode;
    reg_rdata_o[BIT_TOG]   = tog_q;
    reg_rdata_o[BIT_RDY]   = txrdy_q;
  end

  assign txrdy_o  = txrdy_q;
  assign dir_tx_o = shared_fifo_i ? ctrl.dir_tx : 1'b1;

  // R7
  flush_tog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (reg_rdata_o[BIT_TOG] != $past(reg_rdata_o[BIT_TOG])) && !txrdy_o);
  // R7
  flush_selfclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !reg_we_i) |=> !flush_o && !reg_rdata_o[BIT_FTOG]);
  // R6
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !txrdy_o);
  // R9
  dma_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[BIT_DMAEN] |-> !dma_req_o);
endmodule

// File: tb/sim_tx_ep_ctrl.sv
`timescale 1ns/1ps
module sim_tx_ep_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        fifo_wr_i = 1'b0;
  logic [10:0] max_pkt_i = '0;
  logic        ack_i = 1'b0;
  logic        shared_fifo_i = 1'b0;
  logic        txrdy_o, flush_o, dir_tx_o;
  logic        dma_pkt_done_i = 1'b0, dma_all_done_i = 1'b0;
  logic        dma_req_o, dma_irq_o, mode_err_o;

  int checks = 0;
  int errors = 0;
  logic exp_tog = 1'b0;

  always #4 clk_i = ~clk_i;

  tx_ep_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we_i = 1'b1; reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic byte_in();
    fifo_wr_i = 1'b1; cyc(); fifo_wr_i = 1'b0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
    exp_tog = ~exp_tog;
    chk("R6 txrdy", txrdy_o, 0);
    chk("R6 toggle", reg_rdata_o[1], exp_tog);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    chk("R1 rdata", reg_rdata_o, 8'h00);
    chk("R1 outs", {txrdy_o, flush_o, dma_req_o, dma_irq_o, mode_err_o}, 0);
    rst_ni = 1'b1;
    cyc();

    // R2: reserved and toggle bits ignore writes
    wr(8'h42);
    chk("R2 rsvd/tog", reg_rdata_o, 8'h00);

    // R3 R4 R5 R6: sweep sizes and lengths, auto-set on and off
    for (int a = 0; a < 2; a++) begin
      wr(a ? 8'h80 : 8'h00);
      for (int m = 1; m <= 6; m++) begin
        max_pkt_i = 11'(m);
        for (int len = 0; len <= m; len++) begin
          for (int b = 1; b <= len; b++) begin
            byte_in();
            chk(a ? "R3 autoset" : "R4 autoset off", txrdy_o,
                (a == 1 && b == m) ? 1 : 0);
          end
          if (!txrdy_o) begin
            wr(a ? 8'h81 : 8'h01);
            chk("R5 manual set", txrdy_o, 1);
          end
          do_ack();
        end
      end
    end

    // R4: max size 0 never triggers
    wr(8'h80); max_pkt_i = '0;
    for (int b = 0; b < 4; b++) byte_in();
    chk("R4 max zero", txrdy_o, 0);
    wr(8'h80);
    chk("R5 write 0 no effect", txrdy_o, 0);

    // R7: forced toggle mid-load clears count and ready
    max_pkt_i = 11'd4;
    byte_in(); byte_in(); byte_in();
    wr(8'h88);
    chk("R7 flush high", flush_o, 1);
    chk("R7 bit3 reads 1", reg_rdata_o[3], 1);
    cyc();
    exp_tog = ~exp_tog;
    chk("R7 flush once", flush_o, 0);
    chk("R7 bit3 clears", reg_rdata_o[3], 0);
    chk("R7 toggle", reg_rdata_o[1], exp_tog);
    byte_in();
    chk("R7 count cleared", txrdy_o, 0);
    byte_in(); byte_in(); byte_in();
    chk("R3 after flush", txrdy_o, 1);
    wr(8'h88); cyc();
    exp_tog = ~exp_tog;
    chk("R7 ready cleared", txrdy_o, 0);
    chk("R7 toggle 2", reg_rdata_o[1], exp_tog);

    // R8: direction select
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 2; d++) begin
        shared_fifo_i = s[0];
        wr(d ? 8'h20 : 8'h00);
        chk("R8 dir", dir_tx_o, (s == 0) ? 1 : d);
      end

    // R9: DMA request
    chk("R9 req off", dma_req_o, 0);
    wr(8'h10);
    chk("R9 req on", dma_req_o, 1);
    wr(8'h11);
    chk("R9 req ready", dma_req_o, 0);
    do_ack();
    chk("R9 req after ack", dma_req_o, 1);

    // R10: interrupt source per mode
    for (int md = 0; md < 3; md++) begin
      if (md == 0) wr(8'h10);
      if (md == 1) wr(8'h14);
      if (md == 2) begin wr(8'h04); wr(8'h00); end
      for (int src = 0; src < 2; src++) begin
        dma_pkt_done_i = (src == 0); dma_all_done_i = (src == 1);
        cyc();
        dma_pkt_done_i = 1'b0; dma_all_done_i = 1'b0;
        chk("R10 irq", dma_irq_o, (md == 0 && src == 0) || (md == 1 && src == 1));
        cyc();
        chk("R10 irq pulse", dma_irq_o, 0);
      end
    end

    // R11: ordering rule
    wr(8'h14);
    wr(8'h00);
    chk("R11 mode kept", reg_rdata_o[2], 1);
    chk("R11 enable cleared", reg_rdata_o[4], 0);
    chk("R11 err", mode_err_o, 1);
    wr(8'h14);
    chk("R11 err pulse", mode_err_o, 0);
    wr(8'h10);
    chk("R11 mode kept 2", reg_rdata_o[2], 1);
    wr(8'h04);
    chk("R11 legal disable", reg_rdata_o[4:2], 3'b001);
    wr(8'h00);
    chk("R11 legal clear", reg_rdata_o[2], 0);
    chk("R11 no err", mode_err_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule